// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device from power-up to a usable state. After reset it waits in an idle state and drives no-operation commands. A start pulse then launches a fixed command sequence. The sequence is one precharge of all banks, then eight auto-refresh commands, then one load of the mode register. During the load, the caller-supplied mode word is placed on the address lines. Programmable gap counts separate consecutive commands, and no-operation commands fill each gap.

When the last gap has elapsed, the block raises its done flag. It then stays in normal operation and runs a refresh timer that pulses a refresh request at a programmable period. The normal read/write controller consumes this request. A start pulse given during the sequence or after completion has no effect. Only a reset restarts the bring-up.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: A start pulse sampled in the idle state makes the next cycle a precharge-all command. The command is {cs_n,ras_n,cas_n,we_n} = 0,0,1,0, with address bit 10 set, every other address bit 0, and bank 0.
- R2: Exactly eight auto-refresh commands ({cs_n,ras_n,cas_n,we_n} = 0,0,0,1, address and bank 0) follow the precharge, and no other command comes between them.
- R3: After the eighth refresh, exactly one load-mode command (0,0,0,0) is issued. The address bus carries mode_word and the bank bus is 0 in that cycle.
- R4: Consecutive commands are separated by max(T,1) cycles of no-operation (0,1,1,1, address and bank 0). T is gap_precharge after the precharge, gap_refresh after each refresh and gap_mode after the load-mode.
- R5: busy is high from the precharge cycle through the last gap cycle after the load-mode. done rises in the following cycle and stays high until reset, and busy and done are never high together.
- R6: Once done is high, refresh_req is high for one cycle every P cycles, the first time P cycles after done rises. P is refresh_period, and 0 acts as 1. refresh_req is low while done is low.
- R7: start is ignored while busy is high and after done is high: the command sequence, busy and done are unaffected.
- R8: rst_n low, asynchronously and at any point, returns the block to idle. In idle, no-operation is driven and busy, done and refresh_req are low. A later start runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the bring-up sequence from idle |
| mode_word | input | ADDR_W | Value written to the mode register |
| gap_precharge | input | WAIT_W | Gap after the precharge, in cycles |
| gap_refresh | input | WAIT_W | Gap after each auto-refresh, in cycles |
| gap_mode | input | WAIT_W | Gap after the mode load, in cycles |
| refresh_period | input | REF_W | Refresh request period, in cycles |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W | Address bus |
| cmd_bank | output | BANK_W | Bank select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Device initialized, normal operation |
| refresh_req | output | 1 | Periodic refresh request pulse |

## Verification
The bench builds the block with a 3-bit gap width and a 4-bit refresh period width. It sweeps every combination of the three gaps over 0 to 3, so the zero-gap clamp and multi-cycle gaps meet in every order. Across these runs the refresh period cycles through 0 to 4, which covers the zero-as-one rule and back-to-back requests. Every cycle of each run is compared against a schedule computed from the gap values. Start pulses are injected mid-sequence and after completion, and one run is cut short by a reset.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PRE_GAP,
    ST_REF,
    ST_REF_GAP,
    ST_MRS,
    ST_MRS_GAP,
    ST_RUN
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  localparam sdram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdram_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdram_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sdram_cmd_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_gap_timer.sv
// Counts the no-operation gap after a command. A load value of 0 acts as 1.
module sdram_gap_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = (load_val == '0) ? WAIT_W'(1) : load_val;
    else      cnt_d = cnt_q - WAIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == WAIT_W'(1));
endmodule

// File: rtl/sdram_refresh_timer.sv
// Free-running refresh interval counter, active only while enabled.
module sdram_refresh_timer #(
  parameter int REF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [REF_W-1:0] period,
  output logic             req
);
  logic [REF_W-1:0] cnt_q, cnt_d, last;
  logic             hit, req_d, req_q;

  always_comb begin
    last  = (period == '0) ? '0 : period - REF_W'(1);
    hit   = en & (cnt_q >= last);
    cnt_d = (!en || hit) ? '0 : cnt_q + REF_W'(1);
    req_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

  assert_req_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> en);
endmodule

// File: rtl/sdram_cmd_encode.sv
// Maps the sequencer state to the command pins, address and bank.
module sdram_cmd_encode
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  seq_state_e        state,
  input  logic [ADDR_W-1:0] mode_word,
  output sdram_cmd_t        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank
);
  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    bank = '0;
    unique case (state)
      ST_PRE: begin
        cmd          = CMD_PRE;
        addr[AP_BIT] = 1'b1;
      end
      ST_REF: cmd = CMD_REF;
      ST_MRS: begin
        cmd  = CMD_LMR;
        addr = mode_word;
      end
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 2,
  parameter int AP_BIT    = 10,
  parameter int WAIT_W    = 8,
  parameter int REF_W     = 12,
  parameter int N_REFRESH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic [WAIT_W-1:0] gap_precharge,
  input  logic [WAIT_W-1:0] gap_refresh,
  input  logic [WAIT_W-1:0] gap_mode,
  input  logic [REF_W-1:0]  refresh_period,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              busy,
  output logic              done,
  output logic              refresh_req
);
  localparam int RC_W = $clog2(N_REFRESH + 1);

  seq_state_e        state_q, state_d;
  logic [RC_W-1:0]   ref_cnt_q, ref_cnt_d;
  logic              ref_cnt_en;
  logic              gap_load, gap_expired;
  logic [WAIT_W-1:0] gap_val;
  sdram_cmd_t        cmd;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_PRE;
      ST_PRE:     state_d = ST_PRE_GAP;
      ST_PRE_GAP: if (gap_expired) state_d = ST_REF;
      ST_REF:     state_d = ST_REF_GAP;
      ST_REF_GAP: if (gap_expired)
                    state_d = (ref_cnt_q == RC_W'(N_REFRESH)) ? ST_MRS : ST_REF;
      ST_MRS:     state_d = ST_MRS_GAP;
      ST_MRS_GAP: if (gap_expired) state_d = ST_RUN;
      ST_RUN:     state_d = ST_RUN;
      default:    state_d = ST_IDLE;
    endcase
  end

  // refresh counter and gap loading
  always_comb begin
    ref_cnt_en = (state_q == ST_IDLE) | (state_q == ST_REF);
    ref_cnt_d  = (state_q == ST_IDLE) ? '0 : ref_cnt_q + RC_W'(1);
    gap_load   = (state_q == ST_PRE) | (state_q == ST_REF) | (state_q == ST_MRS);
    unique case (state_q)
      ST_PRE:  gap_val = gap_precharge;
      ST_REF:  gap_val = gap_refresh;
      default: gap_val = gap_mode;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (ref_cnt_en) ref_cnt_q <= ref_cnt_d;
    end
  end

  sdram_gap_timer #(.WAIT_W(WAIT_W)) i_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .expired  (gap_expired)
  );

  sdram_cmd_encode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT)) i_enc (
    .state     (state_q),
    .mode_word (mode_word),
    .cmd       (cmd),
    .addr      (cmd_addr),
    .bank      (cmd_bank)
  );

  assign busy = (state_q != ST_IDLE) && (state_q != ST_RUN);
  assign done = (state_q == ST_RUN);

  sdram_refresh_timer #(.REF_W(REF_W)) i_rtmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (done),
    .period (refresh_period),
    .req    (refresh_req)
  );

  assign cmd_cs_n  = cmd.cs_n;
  assign cmd_ras_n = cmd.ras_n;
  assign cmd_cas_n = cmd.cas_n;
  assign cmd_we_n  = cmd.we_n;

  assert_precharge_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd == CMD_PRE && cmd_addr[AP_BIT] && cmd_bank == '0));

  assert_eight_refreshes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (ref_cnt_q == RC_W'(N_REFRESH)));

  assert_mode_on_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (cmd_addr == mode_word && cmd_bank == '0));

  assert_nop_after_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !busy));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

// File: tb/test_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module test_sdram_pwrup_seq;
  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int WAIT_W = 3;
  localparam int REF_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] mode_word = '0;
  logic [WAIT_W-1:0] gap_precharge = '0, gap_refresh = '0, gap_mode = '0;
  logic [REF_W-1:0]  refresh_period = '0;
  logic              cs_n, ras_n, cas_n, we_n, busy, done, refresh_req;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bank;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdram_pwrup_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(10), .WAIT_W(WAIT_W),
                    .REF_W(REF_W), .N_REFRESH(8)) i_sdram_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
    .gap_precharge(gap_precharge), .gap_refresh(gap_refresh), .gap_mode(gap_mode),
    .refresh_period(refresh_period),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_addr(addr), .cmd_bank(bank), .busy(busy), .done(done),
    .refresh_req(refresh_req)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] code();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk_idle(input string req);
    chk(code() == 4'b0111, req, "idle command", code(), 4'b0111);
    chk(addr == '0 && bank == '0, req, "idle addr", addr, 0);
    chk({busy, done, refresh_req} == 3'b000, req, "idle flags", {busy, done, refresh_req}, 0);
  endtask

  task automatic run_case(input int trp, input int trfc, input int tmrd, input int per,
                          input logic [ADDR_W-1:0] mw);
    int gp, gf, gm, m, d, pe, last;
    gp = (trp == 0) ? 1 : trp;
    gf = (trfc == 0) ? 1 : trfc;
    gm = (tmrd == 0) ? 1 : tmrd;
    m  = gp + 1 + 8 * (gf + 1);
    d  = m + gm + 1;
    pe = (per == 0) ? 1 : per;
    last = d + 3 * pe + 2;
    gap_precharge = WAIT_W'(trp); gap_refresh = WAIT_W'(trfc); gap_mode = WAIT_W'(tmrd);
    refresh_period = REF_W'(per); mode_word = mw;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R8");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R8");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= last; c++) begin
      logic [3:0] ec;
      logic [ADDR_W-1:0] ea;
      string rq;
      bit er;
      ec = 4'b0111; ea = '0; rq = "R4";
      if (c == 0) begin
        ec = 4'b0010; ea = ADDR_W'(1) << 10; rq = "R1";
      end else if (c >= gp + 1 && c < m && ((c - gp - 1) % (gf + 1)) == 0) begin
        ec = 4'b0001; rq = "R2";
      end else if (c == m) begin
        ec = 4'b0000; ea = mw; rq = "R3";
      end
      chk(code() == ec, rq, $sformatf("command at cycle %0d", c), code(), ec);
      chk(addr == ea && bank == '0, rq, $sformatf("addr/bank at cycle %0d", c), {addr, bank}, {ea, 2'b00});
      chk(busy == (c < d), "R5", $sformatf("busy at cycle %0d", c), busy, c < d);
      chk(done == (c >= d), "R5", $sformatf("done at cycle %0d", c), done, c >= d);
      er = (c > d) && (((c - d) % pe) == 0);
      chk(refresh_req == er, "R6", $sformatf("refresh_req at cycle %0d", c), refresh_req, er);
      if (c == 4) chk(busy && code() == ec, "R7", "start while busy ignored", busy, 1);
      if (c == d + 2) chk(done && !busy && code() == 4'b0111, "R7", "start after done ignored", done, 1);
      start = (c == 3) || (c == d + 1);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R5 watchdog: done actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_idle("R8");
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int e = 0; e < 4; e++) begin
          int idx;
          idx = a * 16 + b * 4 + e;
          run_case(a, b, e, idx % 5, ADDR_W'(13'h0A5A ^ (idx * 13'h0137)));
        end
    // reset in the middle of a sequence
    gap_precharge = 3'd2; gap_refresh = 3'd2; gap_mode = 3'd2;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R8", "busy before mid reset", busy, 1);
    rst_n = 1'b0;
    #0.5;
    chk_idle("R8");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R8");
    run_case(2, 1, 3, 3, 13'h1234);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule